// File: doc/BRIEF.md
# Polyphase Coefficient Address Generator

This block walks a polyphase resampling filter through one output computation and produces the read addresses for a 256-word coefficient store. The store is shared by up to eight filters. Their taps are interleaved one word at a time, so tap k of filter f sits at word k·F + f, where F is the number of interleaved filters. Tap 0 is the weight applied to the newest input sample. It sits at the lowest word that belongs to its filter.

A job starts with a one-cycle start pulse. The pulse captures the filter select, the interleave count (as log2 F), the symmetry mode, the multiplier count NMULT, the delay count (as log2 NDELAY) and the polyphase phase p. The filter length is QTAP = NDELAY·NMULT. For a given phase, the job visits slots m = 0 … NMULT−1, and slot m uses tap k = p + m·NDELAY.

A symmetric filter stores only its first QTAP/2 taps. Any tap past that half is read from its mirror word QTAP−1−k. The tap at index QTAP/2−1 is the center tap and is flagged. Two slots are issued per clock to feed a datapath that does two multiplies per cycle. A done pulse marks the final pair.

Top module: `coef_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, busy_o, done_o, vld_o and ctr_o are 0 and addr_o is 0.
- R2: A start_i seen while idle captures the configuration, and busy_o is 1 from the next cycle. The pair for cycle 0 is shown one cycle after the capturing edge. A start_i seen while busy is ignored.
- R3: In output cycle c, lane 0 (addr_o[7:0]) carries slot 2c and lane 1 (addr_o[15:8]) carries slot 2c+1. Slot m uses tap k = (p mod NDELAY) + m·NDELAY, with NDELAY = 2^cfg_dlog_i.
- R4: The address is idx·F + (cfg_sel_i mod F), where F = 2^cfg_flog_i and idx is the stored tap index.
- R5: With cfg_sym_i = 1, a tap k ≥ QTAP/2 uses idx = QTAP−1−k, and any other tap uses idx = k.
- R6: ctr_o[lane] is 1 exactly when cfg_sym_i = 1, the slot is valid and k = QTAP/2−1.
- R7: With cfg_sym_i = 0, idx = k and ctr_o stays 0.
- R8: A slot whose address would be 256 or more is suppressed: its vld_o bit is 0 and its address field is 0.
- R9: A job lasts ceil(NMULT/2) output cycles, and slots at or beyond NMULT have vld_o 0. done_o is 1 only in the cycle of the last pair, and busy_o is 0 from that cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures the configuration when idle |
| cfg_sel_i | input | 3 | Filter select within the interleave |
| cfg_flog_i | input | 2 | log2 of the number of interleaved filters |
| cfg_sym_i | input | 1 | 1 = symmetric (half stored), 0 = all taps stored |
| cfg_nmult_i | input | 7 | Multiplier slots per output (NMULT) |
| cfg_dlog_i | input | 3 | log2 of NDELAY |
| cfg_phase_i | input | 6 | Polyphase phase index |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Pulse with the final address pair |
| vld_o | output | 2 | Per-lane address valid |
| addr_o | output | 16 | Two packed 8-bit addresses, lane 0 in the low byte |
| ctr_o | output | 2 | Per-lane center-tap flag |

## Verification
The bench drives jobs across these corner cases:
- The typical symmetric setting, where taps past the half must fold back. A design that skipped the fold would read words past the stored half of the filter.
- An odd NMULT. Here lane 1 must go quiet in the last cycle; a wrong design would issue a stray address or stretch the job by a cycle.
- A phase chosen so that the center tap lands on lane 1. This exposes an off-by-one in the center flag or a flag on the wrong lane.
- A non-symmetric filter whose taps run through word 255 and past it. A design that wrapped instead of suppressing would hand the datapath a word from another filter.
- A filter select wider than the interleave count, which catches a design that does not reduce the select.
- A second start while a job is running, which catches a design that restarts or changes phase mid-job.
- A coefficient read from a synchronous memory model, which confirms that the addresses fetch the intended words.

// File: rtl/coef_pkg.sv
package coef_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // Width of a slot index for a given multiplier-count width and lane count.
  function automatic int slot_width(input int mult_w, input int lanes);
    return mult_w + $clog2(lanes) + 1;
  endfunction

endpackage

// File: rtl/coef_seq.sv
module coef_seq
  import coef_pkg::*;
#(
  parameter int MULT_W = 7,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [MULT_W-1:0] nmult_i,
  output logic              accept_o,
  output logic              run_o,
  output logic [MULT_W-1:0] cnt_o,
  output logic              done_o
);

  localparam int LB   = $clog2(LANES);
  localparam int NB_W = MULT_W + LB + 1;

  seq_state_e        state_q;
  logic [MULT_W-1:0] cnt_q;
  logic              done_q;
  logic [NB_W-1:0]   next_base;
  logic              last;

  // First slot of the following cycle; the current cycle is the last one
  // when that slot already lies at or beyond NMULT.
  assign next_base = (NB_W'(cnt_q) + NB_W'(1)) * NB_W'(LANES);
  assign last      = next_base >= NB_W'(nmult_i);
  assign accept_o  = (state_q == SEQ_IDLE) && start_i;
  assign run_o     = (state_q == SEQ_RUN);
  assign cnt_o     = cnt_q;
  assign done_o    = done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
          end
        end
        SEQ_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) begin
            state_q <= SEQ_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/coef_lane.sv
module coef_lane #(
  parameter int ADDR_W  = 8,
  parameter int MULT_W  = 7,
  parameter int DLOG_W  = 3,
  parameter int SEL_W   = 3,
  parameter int FLOG_W  = 2,
  parameter int PHASE_W = 6,
  parameter int SLOT_W  = 9
) (
  input  logic [SLOT_W-1:0]  slot_i,
  input  logic [MULT_W-1:0]  nmult_i,
  input  logic [DLOG_W-1:0]  dlog_i,
  input  logic [FLOG_W-1:0]  flog_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic               sym_i,
  input  logic [PHASE_W-1:0] phase_i,
  output logic               vld_o,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               ctr_o
);

  // Wide enough for slot << dlog plus the interleave shift, with no overflow.
  localparam int K_W = SLOT_W + PHASE_W + (1 << DLOG_W) + (1 << FLOG_W) + 2;

  logic [K_W-1:0] dmask, fmask;
  logic [K_W-1:0] tap_k, qtap, half, idx, full;
  logic           upper, is_ctr, slot_ok, in_range;

  always_comb begin
    dmask    = (K_W'(1) << dlog_i) - K_W'(1);
    fmask    = (K_W'(1) << flog_i) - K_W'(1);
    tap_k    = (K_W'(phase_i) & dmask) + (K_W'(slot_i) << dlog_i);
    qtap     = K_W'(nmult_i) << dlog_i;
    half     = qtap >> 1;
    upper    = sym_i && (tap_k >= half);
    idx      = upper ? (qtap - K_W'(1) - tap_k) : tap_k;
    is_ctr   = sym_i && (half != '0) && (tap_k == half - K_W'(1));
    full     = (idx << flog_i) | (K_W'(sel_i) & fmask);
    slot_ok  = K_W'(slot_i) < K_W'(nmult_i);
    in_range = full < (K_W'(1) << ADDR_W);
    vld_o    = slot_ok && in_range;
    addr_o   = vld_o ? full[ADDR_W-1:0] : '0;
    ctr_o    = vld_o && is_ctr;
  end

endmodule

// File: rtl/coef_addr_gen.sv
module coef_addr_gen
  import coef_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int MULT_W  = 7,
  parameter int DLOG_W  = 3,
  parameter int SEL_W   = 3,
  parameter int PHASE_W = 6,
  parameter int LANES   = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start_i,
  input  logic [SEL_W-1:0]         cfg_sel_i,
  input  logic [$clog2(SEL_W+1)-1:0] cfg_flog_i,
  input  logic                     cfg_sym_i,
  input  logic [MULT_W-1:0]        cfg_nmult_i,
  input  logic [DLOG_W-1:0]        cfg_dlog_i,
  input  logic [PHASE_W-1:0]       cfg_phase_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic [LANES-1:0]         vld_o,
  output logic [LANES*ADDR_W-1:0]  addr_o,
  output logic [LANES-1:0]         ctr_o
);

  localparam int FLOG_W = $clog2(SEL_W + 1);
  localparam int SLOT_W = slot_width(MULT_W, LANES);

  logic               accept, run;
  logic [MULT_W-1:0]  cnt;

  logic [SEL_W-1:0]   sel_q;
  logic [FLOG_W-1:0]  flog_q;
  logic               sym_q;
  logic [MULT_W-1:0]  nmult_q;
  logic [DLOG_W-1:0]  dlog_q;
  logic [PHASE_W-1:0] phase_q;

  logic [LANES-1:0]        lane_vld, lane_ctr;
  logic [LANES*ADDR_W-1:0] lane_addr;
  logic [LANES-1:0]        vld_q, ctr_q;
  logic [LANES*ADDR_W-1:0] addr_q;

  // Configuration is frozen for the whole job.
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      flog_q  <= '0;
      sym_q   <= 1'b0;
      nmult_q <= '0;
      dlog_q  <= '0;
      phase_q <= '0;
    end else if (accept) begin
      sel_q   <= cfg_sel_i;
      flog_q  <= cfg_flog_i;
      sym_q   <= cfg_sym_i;
      nmult_q <= cfg_nmult_i;
      dlog_q  <= cfg_dlog_i;
      phase_q <= cfg_phase_i;
    end
  end

  coef_seq #(
    .MULT_W (MULT_W),
    .LANES  (LANES)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .nmult_i  (nmult_q),
    .accept_o (accept),
    .run_o    (run),
    .cnt_o    (cnt),
    .done_o   (done_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOT_W-1:0] slot;
    assign slot = SLOT_W'(cnt) * SLOT_W'(LANES) + SLOT_W'(l);

    coef_lane #(
      .ADDR_W  (ADDR_W),
      .MULT_W  (MULT_W),
      .DLOG_W  (DLOG_W),
      .SEL_W   (SEL_W),
      .FLOG_W  (FLOG_W),
      .PHASE_W (PHASE_W),
      .SLOT_W  (SLOT_W)
    ) u_lane (
      .slot_i  (slot),
      .nmult_i (nmult_q),
      .dlog_i  (dlog_q),
      .flog_i  (flog_q),
      .sel_i   (sel_q),
      .sym_i   (sym_q),
      .phase_i (phase_q),
      .vld_o   (lane_vld[l]),
      .addr_o  (lane_addr[l*ADDR_W +: ADDR_W]),
      .ctr_o   (lane_ctr[l])
    );
  end

  // Registered outputs: zero outside a job.
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      vld_q  <= '0;
      ctr_q  <= '0;
      addr_q <= '0;
    end else begin
      vld_q  <= lane_vld;
      ctr_q  <= lane_ctr;
      addr_q <= lane_addr;
    end
  end

  assign busy_o = run;
  assign vld_o  = vld_q;
  assign ctr_o  = ctr_q;
  assign addr_o = addr_q;

endmodule

// File: rtl/coef_addr_gen_chk.sv
module coef_addr_gen_chk #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start_i,
  input logic                    busy_o,
  input logic                    done_o,
  input logic [LANES-1:0]        vld_o,
  input logic [LANES*ADDR_W-1:0] addr_o,
  input logic [LANES-1:0]        ctr_o
);

  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && vld_o == '0 && ctr_o == '0));

  a_r2_start_accept: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);

  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  a_r9_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);

  a_r6_one_center: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ctr_o));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r8_dead_lane_zero: assert property (@(posedge clk) disable iff (rst)
      !vld_o[l] |-> (addr_o[l*ADDR_W +: ADDR_W] == '0));

    a_r6_center_valid: assert property (@(posedge clk) disable iff (rst)
      ctr_o[l] |-> vld_o[l]);
  end

endmodule

bind coef_addr_gen coef_addr_gen_chk #(
  .ADDR_W (ADDR_W),
  .LANES  (LANES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .vld_o   (vld_o),
  .addr_o  (addr_o),
  .ctr_o   (ctr_o)
);

// File: tb/coef_addr_gen_tb.sv
module coef_addr_gen_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [2:0]  cfg_sel_i = '0;
  logic [1:0]  cfg_flog_i = '0;
  logic        cfg_sym_i = 1'b0;
  logic [6:0]  cfg_nmult_i = '0;
  logic [2:0]  cfg_dlog_i = '0;
  logic [5:0]  cfg_phase_i = '0;
  logic        busy_o, done_o;
  logic [1:0]  vld_o, ctr_o;
  logic [15:0] addr_o;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coef_addr_gen u_dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_flog_i  (cfg_flog_i),
    .cfg_sym_i   (cfg_sym_i),
    .cfg_nmult_i (cfg_nmult_i),
    .cfg_dlog_i  (cfg_dlog_i),
    .cfg_phase_i (cfg_phase_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .vld_o       (vld_o),
    .addr_o      (addr_o),
    .ctr_o       (ctr_o)
  );

  // Synchronous coefficient store read by lane 0.
  logic [15:0] mem [256];
  logic [15:0] rd_q;
  initial for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
  always_ff @(posedge clk) rd_q <= mem[addr_o[7:0]];

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected result for one slot, computed from the requirements.
  task automatic expect_slot(input int m, input int nm, input int dl, input int fl,
                             input int sel, input bit sym, input int ph,
                             output bit v, output int a, output bit c);
    int nd, q, k, idx;
    nd = 1 << dl;
    q  = nm * nd;
    k  = (ph % nd) + m * nd;
    idx = (sym && k >= q / 2) ? (q - 1 - k) : k;
    a  = idx * (1 << fl) + (sel % (1 << fl));
    c  = sym && (k == q / 2 - 1);
    v  = (m < nm) && (a < 256);
    if (!v) begin
      a = 0;
      c = 1'b0;
    end
  endtask

  task automatic run_job(input int nm, input int dl, input int fl, input int sel,
                         input bit sym, input int ph, input string req, input bit poke);
    int  ncyc, prev_a;
    bit  prev_v;
    @(negedge clk);
    cfg_nmult_i = 7'(nm); cfg_dlog_i = 3'(dl); cfg_flog_i = 2'(fl);
    cfg_sel_i = 3'(sel); cfg_sym_i = sym; cfg_phase_i = 6'(ph);
    start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
    ncyc = (nm == 0) ? 1 : (nm + 1) / 2;
    prev_v = 1'b0;
    prev_a = 0;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk);
      #1;
      for (int l = 0; l < 2; l++) begin
        bit v, cf;
        int a;
        expect_slot(2 * c + l, nm, dl, fl, sel, sym, ph, v, a, cf);
        chk({req, " vld"}, int'(vld_o[l]), int'(v));
        chk({req, " addr"}, int'(addr_o[l*8 +: 8]), a);
        chk("R6 center", int'(ctr_o[l]), int'(cf));
      end
      if (prev_v) chk("R4 coefficient fetch", int'(rd_q), (prev_a * 37 + 5) & 16'hFFFF);
      prev_v = vld_o[0];
      prev_a = int'(addr_o[7:0]);
      chk("R9 done", int'(done_o), int'(c == ncyc - 1));
      chk("R9 busy", int'(busy_o), int'(c != ncyc - 1));
      if (poke && c == 0) begin
        // R2: a start during the job with another phase must change nothing.
        start_i = 1'b1;
        cfg_phase_i = 6'(ph ^ 1);
        cfg_sym_i = ~sym;
      end else begin
        start_i = 1'b0;
      end
    end
    start_i = 1'b0;
    @(posedge clk);
    #1;
    chk("R9 idle after done", int'(busy_o), 0);
    chk("R9 outputs cleared", int'(vld_o), 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 vld", int'(vld_o), 0);
    chk("R1 addr", int'(addr_o), 0);
    @(negedge clk) rst = 1'b0;
    @(posedge clk);
    #1;
    chk("R1 idle after release", int'(busy_o), 0);
  endtask

  // R5 typical symmetric set: taps past 240 fold; center at slot 7 (lane 1).
  task automatic t_typical;
    run_job(15, 5, 0, 0, 1'b1, 15, "R5", 1'b0);
  endtask

  // R7 non-symmetric, all taps stored.
  task automatic t_nonsym;
    run_job(7, 5, 0, 0, 1'b0, 0, "R7", 1'b0);
  endtask

  // R4 four filters interleaved, filter 3.
  task automatic t_interleave;
    run_job(6, 3, 2, 3, 1'b1, 5, "R4", 1'b0);
  endtask

  // R4 select wider than interleave count is reduced modulo F.
  task automatic t_sel_mod;
    run_job(8, 2, 1, 3, 1'b0, 2, "R4", 1'b0);
  endtask

  // R5 small symmetric fold with odd NMULT (R9) and center on lane 1 (R6).
  task automatic t_small_fold;
    run_job(7, 2, 0, 0, 1'b1, 1, "R5", 1'b0);
  endtask

  // R8 addresses run through 255 and then beyond; phase masked per R3.
  task automatic t_overflow;
    run_job(15, 5, 0, 0, 1'b0, 31, "R8", 1'b0);
  endtask

  // R3 phase larger than NDELAY wraps modulo NDELAY.
  task automatic t_phase_mask;
    run_job(5, 2, 0, 0, 1'b0, 13, "R3", 1'b0);
  endtask

  // R2 start during a running job is ignored.
  task automatic t_start_busy;
    run_job(9, 4, 1, 0, 1'b1, 6, "R2", 1'b1);
  endtask

  initial begin
    t_reset();
    t_typical();
    t_nonsym();
    t_interleave();
    t_sel_mod();
    t_small_fold();
    t_overflow();
    t_phase_mask();
    t_start_busy();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

endmodule